// File: doc/BRIEF.md
# Display Blink and Bank Alternation Controller

This block decides, cycle by cycle, whether a segment display is lit and which of two display-memory banks feeds the display latch. It divides a slow oscillator enable into display frames of 24 oscillator ticks. It then divides frames into blink periods of 768, 1536 or 3072 ticks. It drives two outputs: a display-on gate and an output bank select. The display latch applies the gate to all segments. The bank select chooses between the primary memory bits (bit 0, or bits 0 and 1) and the alternate bits (bit 2, or bits 2 and 3).

There are two blink styles. Whole-display blanking switches the gate off for the second half of each blink period. Bank alternation keeps the display lit and swaps to the alternate bank for the second half of the period, so only the segments whose alternate bits differ appear to blink. Bank selection only exists for the static and 1:2 multiplex drives. With 1:3 and 1:4 drives the alternation request falls back to blanking. The blink phase moves only on frame boundaries, so a frame is never drawn partly in one phase and partly in the other. Clearing the display enable blanks the display at once.

Top module: `lcdb_blinker`

## Requirements
- R1: After reset the frame and blink counters are zero and the blink phase is the first half (primary / lit). With `disp_en` high, `disp_on` is 1 before any oscillator tick.
- R2: A frame boundary occurs on every 24th clock cycle in which `osc_en` is high. Cycles with `osc_en` low advance nothing.
- R3: `blink_mode` = 0 turns blinking off. From the next frame boundary the phase stays in the first half and the blink count is held at zero.
- R4: `blink_mode` 1, 2 and 3 give blink periods of 768, 1536 and 3072 oscillator ticks with a 50% duty. The display is lit (or shows the primary bank) for the first half, counted from reset or from the end of blink-off.
- R5: The blink phase changes only on a frame boundary. A change of `blink_mode` takes effect at the next boundary.
- R6: With `alt_blink` low and `drive_mode` 0 (static) or 1 (1:2), `out_bank` follows `bank_sel` (1 = alternate bits 2/3).
- R7: With `drive_mode` 2 (1:3) or 3 (1:4), `out_bank` is always 0, whatever `bank_sel` and `alt_blink` are.
- R8: With `alt_blink` high and `drive_mode` 0 or 1, the display stays lit through the whole blink period. `out_bank` is 0 in the first half and 1 in the second half, overriding `bank_sel`.
- R9: With `drive_mode` 2 or 3, `alt_blink` is ignored and the second half of each blink period blanks the display.
- R10: `disp_en` low forces `disp_on` to 0 in the same cycle, whatever the blink phase, mode or alternation setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle oscillator tick enable |
| blink_mode | input | 2 | 0 off, 1 = 768-tick, 2 = 1536-tick, 3 = 3072-tick period |
| alt_blink | input | 1 | Blink by bank alternation instead of blanking |
| bank_sel | input | 1 | Static output bank choice when not alternating |
| drive_mode | input | 2 | 0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4 multiplex |
| disp_en | input | 1 | Display enable; low blanks immediately |
| disp_on | output | 1 | Display-on gate to the display latch |
| out_bank | output | 1 | 1 selects alternate bank bits |

## Verification
Each blink rate is run with a steady oscillator tick and sampled one tick before and exactly at each half-period edge. This separates a correct period from one that is one frame early or late, and it separates 50% duty from a skewed split. The same tick counts are repeated across all four drive modes, with alternation on and off and with both static bank choices. This shows which drive modes blank, which alternate and which ignore the bank inputs. A gapped oscillator tick checks that only enabled cycles count. A blink-off request issued mid-frame checks that the phase waits for the frame boundary. Dropping the display enable in the lit half shows that blanking takes effect at once.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

   typedef enum logic [1:0] {
      DRV_STATIC  = 2'd0,
      DRV_DUPLEX  = 2'd1,
      DRV_TRIPLEX = 2'd2,
      DRV_QUAD    = 2'd3
   } drive_e;

   typedef enum logic [1:0] {
      BLK_OFF  = 2'd0,
      BLK_FAST = 2'd1,
      BLK_MID  = 2'd2,
      BLK_SLOW = 2'd3
   } blink_e;

   // True when the drive mode has an alternate bank available.
   function automatic logic bank_capable(input drive_e d);
      return (d == DRV_STATIC) || (d == DRV_DUPLEX);
   endfunction

endpackage

// File: rtl/lcdb_frame_div.sv
module lcdb_frame_div #(
   parameter int OSC_PER_FRAME = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   output logic frame_tick
);
   localparam int CW   = (OSC_PER_FRAME > 1) ? $clog2(OSC_PER_FRAME) : 1;
   localparam logic [CW-1:0] LAST = CW'(OSC_PER_FRAME - 1);
   localparam bit POW2 = (OSC_PER_FRAME & (OSC_PER_FRAME - 1)) == 0;

   if (OSC_PER_FRAME < 2) begin : g_bad_len
      $error("lcdb_frame_div: OSC_PER_FRAME must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   if (POW2) begin : g_wrap
      // Power-of-two frame: natural wrap, no compare-and-clear.
      always_ff @(posedge clk) begin
         if (!rst_n)      cnt_q <= '0;
         else if (osc_en) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n)           cnt_q <= '0;
         else if (osc_en) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign frame_tick = osc_en && (cnt_q == LAST);

   AST_FRAME_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);  // R2
   AST_HOLD_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> $stable(cnt_q));  // R2
   AST_WRAP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/lcdb_blink_phase.sv
module lcdb_blink_phase
   import lcdb_pkg::*;
#(
   parameter int FAST_HALF_FRAMES = 16,
   parameter int MODE_W           = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic [MODE_W-1:0] blink_mode,
   output logic              phase
);
   localparam int NUM_RATES = (1 << MODE_W) - 1;
   localparam int LOG_HALF  = (FAST_HALF_FRAMES > 1) ? $clog2(FAST_HALF_FRAMES) : 0;
   localparam int CNT_W     = LOG_HALF + NUM_RATES;

   if ((FAST_HALF_FRAMES & (FAST_HALF_FRAMES - 1)) != 0 || FAST_HALF_FRAMES < 1) begin : g_bad_half
      $error("lcdb_blink_phase: FAST_HALF_FRAMES must be a power of two");
   end
   if (MODE_W != 2) begin : g_bad_mode
      $error("lcdb_blink_phase: mode encoding assumes MODE_W == 2");
   end

   logic [CNT_W-1:0]   cnt_q, cnt_nxt;
   logic [NUM_RATES:0] cand;
   logic               phase_q;
   logic               off;

   assign off     = (blink_mode == BLK_OFF);
   assign cnt_nxt = off ? '0 : cnt_q + 1'b1;

   // Each slower rate takes the next higher count bit as its phase.
   assign cand[0] = 1'b0;
   for (genvar r = 1; r <= NUM_RATES; r++) begin : g_rate
      assign cand[r] = cnt_nxt[LOG_HALF + r - 1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (frame_tick) begin
         cnt_q   <= cnt_nxt;
         phase_q <= cand[blink_mode];
      end
   end

   assign phase = phase_q;

   AST_PHASE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_q) |-> $past(frame_tick));  // R5
   AST_OFF_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && off) |=> (!phase_q && cnt_q == '0));  // R3
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(cnt_q));  // R5

endmodule

// File: rtl/lcdb_out_sel.sv
module lcdb_out_sel
   import lcdb_pkg::*;
(
   input  logic [1:0] drive_mode,
   input  logic       alt_blink,
   input  logic       bank_sel,
   input  logic       disp_en,
   input  logic       phase,
   output logic       disp_on,
   output logic       out_bank
);
   drive_e drv;
   logic   can_bank;
   logic   alternating;
   logic   blank_half;

   assign drv         = drive_e'(drive_mode);
   assign can_bank    = bank_capable(drv);
   assign alternating = alt_blink && can_bank;
   assign blank_half  = phase && !alternating;

   always_comb begin
      disp_on  = disp_en && !blank_half;
      if (!can_bank)        out_bank = 1'b0;
      else if (alternating) out_bank = phase;
      else                  out_bank = bank_sel;
   end

endmodule

// File: rtl/lcdb_blinker.sv
module lcdb_blinker
   import lcdb_pkg::*;
#(
   parameter int OSC_PER_FRAME    = 24,
   parameter int FAST_HALF_FRAMES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic [1:0] blink_mode,
   input  logic       alt_blink,
   input  logic       bank_sel,
   input  logic [1:0] drive_mode,
   input  logic       disp_en,
   output logic       disp_on,
   output logic       out_bank
);
   logic frame_tick;
   logic phase;

   lcdb_frame_div #(.OSC_PER_FRAME(OSC_PER_FRAME)) frame_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_en     (osc_en),
      .frame_tick (frame_tick)
   );

   lcdb_blink_phase #(.FAST_HALF_FRAMES(FAST_HALF_FRAMES), .MODE_W(2)) phase_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .blink_mode (blink_mode),
      .phase      (phase)
   );

   lcdb_out_sel sel_i (
      .drive_mode (drive_mode),
      .alt_blink  (alt_blink),
      .bank_sel   (bank_sel),
      .disp_en    (disp_en),
      .phase      (phase),
      .disp_on    (disp_on),
      .out_bank   (out_bank)
   );

   AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> !disp_on);  // R10
   AST_WIDE_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      drive_mode[1] |-> !out_bank);  // R7
   AST_ALT_STAYS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_blink && !drive_mode[1] && disp_en) |-> disp_on);  // R8
   AST_OUTS_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(drive_mode) && $stable(alt_blink) && $stable(bank_sel) &&
       $stable(disp_en) && !$past(frame_tick)) |-> ($stable(disp_on) && $stable(out_bank)));  // R5

endmodule

// File: tb/lcdb_blinker_tb.sv
module lcdb_blinker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0;
   logic [1:0] blink_mode = 2'd0;
   logic       alt_blink = 1'b0;
   logic       bank_sel = 1'b0;
   logic [1:0] drive_mode = 2'd0;
   logic       disp_en = 1'b1;
   logic       disp_on;
   logic       out_bank;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   lcdb_blinker dut_i (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .blink_mode(blink_mode),
      .alt_blink(alt_blink), .bank_sel(bank_sel), .drive_mode(drive_mode),
      .disp_en(disp_en), .disp_on(disp_on), .out_bank(out_bank)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic        alt;
      logic        bsel;
      logic [1:0]  drv;
      logic        en;
      logic [15:0] ticks;
      logic        exp_on;
      logic        exp_bank;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 16'd383,  1'b1, 1'b0, 4'd4},  // R4 fast, last lit tick
      '{2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 16'd384,  1'b0, 1'b0, 4'd4},  // R4 fast, blank half
      '{2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 16'd768,  1'b1, 1'b0, 4'd4},  // R4 fast, full period
      '{2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 16'd767,  1'b1, 1'b0, 4'd4},  // R4 mid
      '{2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 16'd768,  1'b0, 1'b0, 4'd4},  // R4 mid
      '{2'd3, 1'b0, 1'b0, 2'd3, 1'b1, 16'd1535, 1'b1, 1'b0, 4'd4},  // R4 slow
      '{2'd3, 1'b0, 1'b0, 2'd3, 1'b1, 16'd1536, 1'b0, 1'b0, 4'd4},  // R4 slow
      '{2'd3, 1'b0, 1'b0, 2'd3, 1'b1, 16'd3072, 1'b1, 1'b0, 4'd4},  // R4 slow wrap
      '{2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 16'd384,  1'b1, 1'b1, 4'd8},  // R8 static alternate half
      '{2'd1, 1'b1, 1'b0, 2'd1, 1'b1, 16'd383,  1'b1, 1'b0, 4'd8},  // R8 1:2 primary half
      '{2'd1, 1'b1, 1'b1, 2'd1, 1'b1, 16'd384,  1'b1, 1'b1, 4'd8},  // R8 1:2 alternate half
      '{2'd1, 1'b1, 1'b1, 2'd1, 1'b1, 16'd768,  1'b1, 1'b0, 4'd8},  // R8 overrides bank_sel
      '{2'd1, 1'b1, 1'b0, 2'd2, 1'b1, 16'd384,  1'b0, 1'b0, 4'd9},  // R9 1:3 blanks
      '{2'd1, 1'b1, 1'b1, 2'd3, 1'b1, 16'd384,  1'b0, 1'b0, 4'd9},  // R9 1:4 blanks
      '{2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 16'd400,  1'b1, 1'b1, 4'd3},  // R3 off stays lit
      '{2'd0, 1'b0, 1'b1, 2'd1, 1'b1, 16'd10,   1'b1, 1'b1, 4'd6},  // R6 1:2 static bank
      '{2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 16'd10,   1'b1, 1'b0, 4'd7},  // R7 1:3 no bank
      '{2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 16'd400,  1'b1, 1'b0, 4'd3},  // R3 off, alt holds primary
      '{2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'd100,  1'b0, 1'b0, 4'd10}, // R10 disabled
      '{2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 16'd400,  1'b0, 1'b1, 4'd10}  // R10 disabled in alternation
   };

   task automatic check(input string req, input logic on_e, input logic bank_e);
      n_cmp++;
      if (disp_on !== on_e || out_bank !== bank_e) begin
         n_bad++;
         $display("FAIL %s: disp_on=%b out_bank=%b expected disp_on=%b out_bank=%b",
                  req, disp_on, out_bank, on_e, bank_e);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      osc_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_ticks(input int n);
      osc_en = 1'b1;
      for (int k = 0; k < n; k++) @(negedge clk);
      osc_en = 1'b0;
   endtask

   initial begin
      // R1: reset state before any tick
      blink_mode = 2'd1; drive_mode = 2'd3; disp_en = 1'b1; bank_sel = 1'b1;
      do_reset();
      check("R1", 1'b1, 1'b0);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         blink_mode = VECS[v].mode;
         alt_blink  = VECS[v].alt;
         bank_sel   = VECS[v].bsel;
         drive_mode = VECS[v].drv;
         disp_en    = VECS[v].en;
         do_reset();
         run_ticks(int'(VECS[v].ticks));
         check($sformatf("R%0d", VECS[v].req), VECS[v].exp_on, VECS[v].exp_bank);
      end

      // R2: gapped oscillator ticks, only enabled cycles count
      blink_mode = 2'd1; alt_blink = 1'b0; bank_sel = 1'b0; drive_mode = 2'd3; disp_en = 1'b1;
      do_reset();
      for (int k = 0; k < 766; k++) begin
         osc_en = (k % 2 == 0);
         @(negedge clk);
      end
      osc_en = 1'b0;
      check("R2", 1'b1, 1'b0);
      repeat (500) @(negedge clk);
      check("R2", 1'b1, 1'b0);
      osc_en = 1'b1; @(negedge clk); osc_en = 1'b0;
      check("R2", 1'b0, 1'b0);

      // R5: blink-off request mid-frame waits for the frame boundary
      do_reset();
      run_ticks(394);
      check("R5", 1'b0, 1'b0);
      blink_mode = 2'd0;
      @(negedge clk);
      check("R5", 1'b0, 1'b0);
      run_ticks(13);
      check("R5", 1'b0, 1'b0);
      run_ticks(1);
      check("R5", 1'b1, 1'b0);

      // R10: immediate blank in the lit half
      blink_mode = 2'd1;
      do_reset();
      run_ticks(100);
      check("R10", 1'b1, 1'b0);
      disp_en = 1'b0;
      #1;
      check("R10", 1'b0, 1'b0);
      disp_en = 1'b1;
      #1;
      check("R10", 1'b1, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule